// File: doc/BRIEF.md
# Floating-Point Reservation Station Bank with Tag Renaming

This block holds a small pool of reservation stations split into two classes: a multiply class and an add/subtract class. It also holds a register file in which every register carries a pending-producer tag. An instruction is issued in program order into the lowest free station of its class. Each source operand either comes as a value, from the register file or from a result being broadcast in that very cycle, or it is recorded as the tag of the station that will produce it. The destination register is then renamed to the new station's tag. Because every consumer names its producer, write-after-read and write-after-write conflicts never stall issue.

Stations watch a single result bus and capture a value when the tag they wait for appears on it. Once both operands are present, a station starts a fixed-latency execution stub. The stub's latency depends on the class. A finished station competes for the result bus, which carries one result per cycle. The station that has waited longest wins, and on equal waits the lowest tag wins. A broadcast frees the producing station and updates every register still renamed to that tag.

Top module: `rs_bank`

## Requirements
- R1: An accepted issue (issue_valid high while issue_ready is high) takes the lowest-indexed free station of its class. Stations 0..NUM_MUL-1 form the multiply class and the remaining stations form the add class. A station's tag is its index plus one, and tag 0 means "no producer". When every station of the class is busy, issue_ready is low and the issue is not taken.
- R2: The op encoding is 00 add, 01 subtract, 1x multiply. An issued station receives the register value of a source whose register has no pending tag. Otherwise it receives that register's pending tag.
- R3: If the producer tag of a source is on the result bus in the issue cycle, the station takes the broadcast value and records no tag.
- R4: A station waiting on a tag captures the bus value in the cycle that tag is broadcast, and then clears the wait.
- R5: A station starts execution only when both operands are present. Add gives a+b, subtract gives a-b, and multiply gives the low DW bits of a*b. Results appear after MUL_LAT or ADD_LAT cycles of counting.
- R6: At most one result is broadcast per cycle. Among finished stations, the one that has been waiting longest is granted, with ties going to the lowest tag. A finished station that is not granted keeps its result for a later cycle.
- R7: A broadcast updates a register only while that register's pending tag equals the broadcast tag, and it then clears the tag. A same-cycle issue to that register installs the new tag instead.
- R8: After all issued work drains, every register holds the value that strict program-order execution would give, whatever the write-after-read or write-after-write overlap.
- R9: After reset all stations are free, register i holds value i with no pending tag, and the bus is idle.
- R10: A station is free in the cycle after its broadcast and can then be issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered for issue |
| issue_op | input | 2 | Operation: 00 add, 01 sub, 1x multiply |
| issue_dst | input | $clog2(NUM_REGS) | Destination register |
| issue_src1 | input | $clog2(NUM_REGS) | First source register |
| issue_src2 | input | $clog2(NUM_REGS) | Second source register |
| issue_ready | output | 1 | A station of the offered op's class is free |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | $clog2(NUM_MUL+NUM_ADD+1) | Tag of the broadcasting station |
| cdb_value | output | DW | Broadcast result |
| rd_addr | input | $clog2(NUM_REGS) | Register inspection address |
| rd_data | output | DW | Value of the inspected register |
| rd_tag | output | $clog2(NUM_MUL+NUM_ADD+1) | Pending tag of the inspected register |

## Verification
Two things can land in the same cycle: an issue that reads a source, and the broadcast of that source's producer. The bench issues a producer and then a consumer of its result, and sweeps the gap between the two issues over every cycle of the producer's life, so that one run places the consumer's issue exactly on the broadcast cycle. It judges the result from the drained register values. The other same-cycle collision happens on the bus. Three adds wait on one multiply and therefore finish together, and a second multiply is swept to finish next to them. The bench requires the three adds to go out on consecutive cycles in tag order.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_MULX = 2'd3
    } rs_op_e;

    function automatic logic is_mul(input logic [1:0] op);
        return op[1];
    endfunction
endpackage

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station #(
    parameter int DW  = 16,
    parameter int TW  = 3,
    parameter int AW  = 4,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [1:0]    alloc_op,
    input  logic [DW-1:0] alloc_vj,
    input  logic [TW-1:0] alloc_qj,
    input  logic [DW-1:0] alloc_vk,
    input  logic [TW-1:0] alloc_qk,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_value,
    input  logic          grant,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] age,
    output logic [DW-1:0] result
);
    import rs_pkg::*;

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic          busy;
        logic [1:0]    op;
        logic [DW-1:0] vj;
        logic [DW-1:0] vk;
        logic [TW-1:0] qj;
        logic [TW-1:0] qk;
        logic          exec;
        logic          done;
        logic [CW-1:0] cnt;
        logic [AW-1:0] age;
        logic [DW-1:0] res;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [DW-1:0] compute(input logic [1:0] op,
                                              input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
        logic [DW-1:0] r;
        case (op)
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            default: r = a * b;
        endcase
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (alloc) begin
                st_d.busy = 1'b1;
                st_d.op   = alloc_op;
                st_d.vj   = alloc_vj;
                st_d.qj   = alloc_qj;
                st_d.vk   = alloc_vk;
                st_d.qk   = alloc_qk;
                st_d.exec = 1'b0;
                st_d.done = 1'b0;
                st_d.cnt  = '0;
                st_d.age  = '0;
            end
        end else begin
            // operand capture from the result bus
            if (st_q.qj != '0 && cdb_valid && cdb_tag == st_q.qj) begin
                st_d.vj = cdb_value;
                st_d.qj = '0;
            end
            if (st_q.qk != '0 && cdb_valid && cdb_tag == st_q.qk) begin
                st_d.vk = cdb_value;
                st_d.qk = '0;
            end
            // dispatch to the fixed-latency stub
            if (!st_q.exec && st_q.qj == '0 && st_q.qk == '0) begin
                st_d.exec = 1'b1;
                st_d.cnt  = CW'(LAT - 1);
                st_d.res  = compute(st_q.op, st_q.vj, st_q.vk);
            end else if (st_q.exec && !st_q.done) begin
                if (st_q.cnt == '0) begin
                    st_d.done = 1'b1;
                    st_d.age  = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            // waiting for the bus
            if (st_q.done) begin
                if (grant) begin
                    st_d.busy = 1'b0;
                    st_d.exec = 1'b0;
                    st_d.done = 1'b0;
                end else if (st_q.age != '1) begin
                    st_d.age = st_q.age + AW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign age    = st_q.age;
    assign result = st_q.res;
endmodule

// File: rtl/rs_cdb_arb.sv
`timescale 1ns/1ps
module rs_cdb_arb #(
    parameter int N  = 5,
    parameter int AW = 4
) (
    input  logic [N-1:0]    done,
    input  logic [N*AW-1:0] age_flat,
    output logic [N-1:0]    grant
);
    logic          found;
    int            best;
    logic [AW-1:0] best_age;

    always_comb begin
        found    = 1'b0;
        best     = 0;
        best_age = '0;
        for (int i = 0; i < N; i++) begin
            if (done[i] && (!found || age_flat[i*AW +: AW] > best_age)) begin
                found    = 1'b1;
                best     = i;
                best_age = age_flat[i*AW +: AW];
            end
        end
        grant = '0;
        if (found) grant[best] = 1'b1;
    end
endmodule

// File: rtl/rs_regfile.sv
`timescale 1ns/1ps
module rs_regfile #(
    parameter int NR = 8,
    parameter int DW = 16,
    parameter int TW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cdb_valid,
    input  logic [TW-1:0]         cdb_tag,
    input  logic [DW-1:0]         cdb_value,
    input  logic [$clog2(NR)-1:0] src1,
    input  logic [$clog2(NR)-1:0] src2,
    output logic [DW-1:0]         src1_val,
    output logic [TW-1:0]         src1_tag,
    output logic [DW-1:0]         src2_val,
    output logic [TW-1:0]         src2_tag,
    input  logic                  wr_en,
    input  logic [$clog2(NR)-1:0] wr_dst,
    input  logic [TW-1:0]         wr_tag,
    input  logic [$clog2(NR)-1:0] rd_addr,
    output logic [DW-1:0]         rd_data,
    output logic [TW-1:0]         rd_tag
);
    typedef struct packed {
        logic [NR-1:0][DW-1:0] val;
        logic [NR-1:0][TW-1:0] qi;
    } rf_t;

    rf_t rf_d, rf_q;

    function automatic rf_t reset_image();
        rf_t r;
        for (int i = 0; i < NR; i++) begin
            r.val[i] = DW'(i);
            r.qi[i]  = '0;
        end
        return r;
    endfunction

    // source lookup with same-cycle bypass from the bus
    always_comb begin
        src1_val = rf_q.val[src1];
        src1_tag = rf_q.qi[src1];
        if (src1_tag != '0 && cdb_valid && cdb_tag == src1_tag) begin
            src1_val = cdb_value;
            src1_tag = '0;
        end
        src2_val = rf_q.val[src2];
        src2_tag = rf_q.qi[src2];
        if (src2_tag != '0 && cdb_valid && cdb_tag == src2_tag) begin
            src2_val = cdb_value;
            src2_tag = '0;
        end
    end

    always_comb begin
        rf_d = rf_q;
        if (cdb_valid) begin
            for (int i = 0; i < NR; i++) begin
                if (rf_q.qi[i] != '0 && rf_q.qi[i] == cdb_tag) begin
                    rf_d.val[i] = cdb_value;
                    rf_d.qi[i]  = '0;
                end
            end
        end
        if (wr_en) rf_d.qi[wr_dst] = wr_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= reset_image();
        else        rf_q <= rf_d;
    end

    assign rd_data = rf_q.val[rd_addr];
    assign rd_tag  = rf_q.qi[rd_addr];
endmodule

// File: rtl/rs_bank.sv
`timescale 1ns/1ps
module rs_bank #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 16,
    parameter int NUM_MUL  = 2,
    parameter int NUM_ADD  = 3,
    parameter int MUL_LAT  = 4,
    parameter int ADD_LAT  = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  issue_valid,
    input  logic [1:0]                            issue_op,
    input  logic [$clog2(NUM_REGS)-1:0]           issue_dst,
    input  logic [$clog2(NUM_REGS)-1:0]           issue_src1,
    input  logic [$clog2(NUM_REGS)-1:0]           issue_src2,
    output logic                                  issue_ready,
    output logic                                  cdb_valid,
    output logic [$clog2(NUM_MUL+NUM_ADD+1)-1:0]  cdb_tag,
    output logic [DW-1:0]                         cdb_value,
    input  logic [$clog2(NUM_REGS)-1:0]           rd_addr,
    output logic [DW-1:0]                         rd_data,
    output logic [$clog2(NUM_MUL+NUM_ADD+1)-1:0]  rd_tag
);
    import rs_pkg::*;

    localparam int NUM_RS = NUM_MUL + NUM_ADD;
    localparam int TW     = $clog2(NUM_RS + 1);
    localparam int AW     = $clog2(NUM_RS) + 1;

    logic [NUM_RS-1:0]    busy_vec;
    logic [NUM_RS-1:0]    done_vec;
    logic [NUM_RS-1:0]    grant_vec;
    logic [NUM_RS-1:0]    alloc_vec;
    logic [NUM_RS*AW-1:0] age_flat;
    logic [DW-1:0]        res_arr [NUM_RS];

    logic [DW-1:0] s1_val, s2_val;
    logic [TW-1:0] s1_tag, s2_tag;
    logic          fire;
    logic [TW-1:0] new_tag;

    // lowest free station of the requested class
    always_comb begin
        issue_ready = 1'b0;
        new_tag     = '0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (!busy_vec[i] && ((i < NUM_MUL) == is_mul(issue_op))) begin
                issue_ready = 1'b1;
                new_tag     = TW'(i + 1);
            end
        end
        fire = issue_valid && issue_ready;
        for (int i = 0; i < NUM_RS; i++) begin
            alloc_vec[i] = fire && (new_tag == TW'(i + 1));
        end
    end

    rs_regfile #(.NR(NUM_REGS), .DW(DW), .TW(TW)) i_regfile (
        .clk(clk), .rst_n(rst_n),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .src1(issue_src1), .src2(issue_src2),
        .src1_val(s1_val), .src1_tag(s1_tag),
        .src2_val(s2_val), .src2_tag(s2_tag),
        .wr_en(fire), .wr_dst(issue_dst), .wr_tag(new_tag),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    for (genvar g = 0; g < NUM_RS; g++) begin : g_st
        localparam int LAT_G = (g < NUM_MUL) ? MUL_LAT : ADD_LAT;
        rs_station #(.DW(DW), .TW(TW), .AW(AW), .LAT(LAT_G)) i_st (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc_vec[g]), .alloc_op(issue_op),
            .alloc_vj(s1_val), .alloc_qj(s1_tag),
            .alloc_vk(s2_val), .alloc_qk(s2_tag),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
            .grant(grant_vec[g]),
            .busy(busy_vec[g]), .done(done_vec[g]),
            .age(age_flat[g*AW +: AW]), .result(res_arr[g])
        );
    end

    rs_cdb_arb #(.N(NUM_RS), .AW(AW)) i_arb (
        .done(done_vec), .age_flat(age_flat), .grant(grant_vec)
    );

    always_comb begin
        cdb_valid = |grant_vec;
        cdb_tag   = '0;
        cdb_value = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (grant_vec[i]) begin
                cdb_tag   = TW'(i + 1);
                cdb_value = res_arr[i];
            end
        end
    end
endmodule

// File: rtl/rs_bank_chk.sv
`timescale 1ns/1ps
module rs_bank_chk #(
    parameter int NUM_RS  = 5,
    parameter int NUM_MUL = 2,
    parameter int TW      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [1:0]        issue_op,
    input logic              issue_ready,
    input logic              cdb_valid,
    input logic [TW-1:0]     cdb_tag,
    input logic [NUM_RS-1:0] busy_vec,
    input logic [NUM_RS-1:0] done_vec,
    input logic [NUM_RS-1:0] grant_vec
);
    logic          class_full;
    logic [TW-1:0] last_tag;
    logic          last_busy;

    always_comb begin
        class_full = 1'b1;
        for (int i = 0; i < NUM_RS; i++) begin
            if ((i < NUM_MUL) == issue_op[1] && !busy_vec[i]) class_full = 1'b0;
        end
        last_busy = 1'b0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (TW'(i + 1) == last_tag) last_busy = busy_vec[i];
        end
    end

    always_ff @(posedge clk) last_tag <= cdb_tag;

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        class_full |-> !issue_ready);                                   // R1
    AST_ISSUE_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready) |=>
        $countones(busy_vec) == $past($countones(busy_vec)) + 1 - int'($past(cdb_valid))); // R1
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));                                           // R6
    AST_GRANT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> $onehot(grant_vec & done_vec));                   // R6
    AST_LOSER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec & ~grant_vec) != '0 |=>
        ($past(done_vec & ~grant_vec) & ~done_vec) == '0);              // R6
    AST_FREE_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> !last_busy);                                      // R10
endmodule

bind rs_bank rs_bank_chk #(.NUM_RS(NUM_RS), .NUM_MUL(NUM_MUL), .TW(TW)) i_rs_bank_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_ready(issue_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .busy_vec(busy_vec), .done_vec(done_vec), .grant_vec(grant_vec)
);

// File: tb/test_rs_bank.sv
`timescale 1ns/1ps
module test_rs_bank;
    localparam int NR = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [1:0]    issue_op = 2'd0;
    logic [2:0]    issue_dst = '0, issue_src1 = '0, issue_src2 = '0;
    logic          issue_ready;
    logic          cdb_valid;
    logic [2:0]    cdb_tag;
    logic [DW-1:0] cdb_value;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [2:0]    rd_tag;

    always #4 clk = ~clk;

    rs_bank i_rs_bank (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_src1(issue_src1), .issue_src2(issue_src2),
        .issue_ready(issue_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_value(cdb_value), .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic log_clr = 1'b1;
    int   log_n;
    int   log_tag [64];
    int   log_cyc [64];
    always @(negedge clk) begin
        if (log_clr) log_n <= 0;
        else if (cdb_valid && log_n < 64) begin
            log_tag[log_n] <= int'(cdb_tag);
            log_cyc[log_n] <= cyc;
            log_n <= log_n + 1;
        end
    end

    logic [DW-1:0] model [NR];
    logic [15:0]   lf = 16'hACE1;

    function automatic logic [DW-1:0] ref_op(input logic [1:0] op, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
        if (op == 2'd0) return a + b;
        if (op == 2'd1) return a - b;
        return a * b;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        issue_valid = 1'b0;
        log_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        log_clr = 1'b0;
        for (int i = 0; i < NR; i++) model[i] = DW'(i);
    endtask

    task automatic issue(input logic [1:0] op, input int dst, input int s1, input int s2);
        @(negedge clk);
        issue_op = op;
        issue_dst = 3'(dst);
        issue_src1 = 3'(s1);
        issue_src2 = 3'(s2);
        issue_valid = 1'b1;
        #1;
        while (!issue_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 issue_valid = 1'b0;
        model[dst] = ref_op(op, model[s1], model[s2]);
    endtask

    task automatic drain();
        repeat (80) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++) begin
            rd_addr = 3'(i);
            #1;
            check_eq(req, int'(rd_data), int'(model[i]));
            check_eq(req, int'(rd_tag), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R9: act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        // R9: reset state
        do_reset();
        #1;
        check_eq("R9 bus idle", int'(cdb_valid), 0);
        issue_op = 2'd2; #1;
        check_eq("R9 mul free", int'(issue_ready), 1);
        issue_op = 2'd0; #1;
        check_eq("R9 add free", int'(issue_ready), 1);
        check_regs("R9 regs");

        // R1 R10: class full stalls, frees after broadcast, lowest tag first
        do_reset();
        issue(2'd2, 1, 2, 3);
        issue(2'd2, 4, 1, 2);
        @(negedge clk);
        issue_op = 2'd2; #1;
        check_eq("R1 mul full stalls", int'(issue_ready), 0);
        issue_op = 2'd0; #1;
        check_eq("R1 add class free", int'(issue_ready), 1);
        drain();
        issue_op = 2'd3; #1;
        check_eq("R10 mul free again", int'(issue_ready), 1);
        check_eq("R1 broadcasts", log_n, 2);
        check_eq("R1 first tag", log_tag[0], 1);
        check_eq("R1 second tag", log_tag[1], 2);
        check_regs("R2 R4 chain");

        // R3: consumer issued at every offset from its producer's broadcast
        for (int k = 0; k < 10; k++) begin
            do_reset();
            issue(2'd0, 3, 1, 2);
            repeat (k) @(negedge clk);
            issue(2'd0, 4, 3, 3);
            drain();
            check_regs("R3 bypass sweep");
        end

        // R6: three adds finish together, a second multiply swept around them
        for (int k = 0; k < 12; k++) begin
            do_reset();
            issue(2'd2, 1, 2, 3);
            issue(2'd0, 4, 1, 0);
            issue(2'd0, 5, 1, 1);
            issue(2'd1, 6, 1, 2);
            repeat (k) @(negedge clk);
            issue(2'd2, 7, 2, 2);
            drain();
            begin
                int p = 0;
                for (int i = 0; i < 62; i++) if (i < log_n && log_tag[i] == 3) p = i;
                check_eq("R6 first add tag", log_tag[p], 3);
                check_eq("R6 second add next", log_tag[p+1], 4);
                check_eq("R6 third add next", log_tag[p+2], 5);
                check_eq("R6 adds back to back", log_cyc[p+2] - log_cyc[p], 2);
            end
            check_regs("R4 R6 values");
        end

        // R7 R8: write-after-write and write-after-read overlap
        do_reset();
        issue(2'd2, 5, 2, 3);
        issue(2'd0, 5, 1, 1);
        issue(2'd2, 2, 6, 7);
        issue(2'd0, 6, 1, 1);
        issue(2'd1, 7, 5, 2);
        drain();
        check_regs("R7 R8 rename");

        // R5 R8: pseudo-random programs against an in-order model
        for (int p = 0; p < 20; p++) begin
            do_reset();
            for (int n = 0; n < 12; n++) begin
                step_lf();
                issue(lf[1:0], int'(lf[4:2]), int'(lf[7:5]), int'(lf[10:8]));
                repeat (int'(lf[12:11]) % 3) @(negedge clk);
            end
            drain();
            check_regs("R5 R8 program");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule